// File: doc/BRIEF.md
# Peak-Current PWM Pulse Terminator

This block produces a fixed-frequency gate pulse for a switching power stage. Each pulse begins at the start of a switching period. It normally ends when a current-sense comparator reports that the inductor current has reached its limit. If the comparator never reports this, the pulse ends at a programmed duty ceiling. The comparator threshold comes from a reference DAC. The block owns that DAC's input word. The word is supplied by an outer voltage loop and takes effect only at period starts. It can be lowered tick by tick in the second half of the period as digital slope compensation.

The raw comparator level first passes through a synchronizer. A blanking window at the start of each pulse then masks the switching spike. Once the comparator ends a pulse, the gate stays low until the next period. Each comparator termination is reported twice: as a one-cycle event and as a sticky limit flag that is cleared by a write.

The reference word arrives on a valid/ready stream with a one-word holding slot. While a word waits for the next period start, `ref_ready` is low and the source must hold its word. A word is accepted on any clock where `ref_valid` and `ref_ready` are both high. At most one new word is applied per period.

Top module: `pkcm_pwm`

## Requirements
- R1: The period counter counts 0 up to `cfg_period` and then returns to 0, so one period is `cfg_period`+1 clocks. The gate is high at count 0 of every period when `cfg_max_on` > 0 and the comparator is quiet.
- R2: The gate is high only while the count is below `cfg_max_on`. A ceiling above `cfg_period` keeps the gate high for the whole period.
- R3: `cmp_raw` passes through two flops before use. A trip sampled at a clock edge lowers the gate from the third edge on, counting that edge as the first.
- R4: A synchronized comparator level is ignored while the count is below `cfg_blank`.
- R5: After the comparator ends a pulse, the gate stays low until the next count 0, even if the comparator is released.
- R6: `lim_event` is high for exactly the one cycle after each comparator termination. It stays low for pulses that end at the duty ceiling.
- R7: `lim_sticky` is set by every comparator termination and cleared by `lim_clr`. A termination in the same cycle as `lim_clr` wins.
- R8: `ref_ready` is low while a word is pending. A pending word becomes the base reference at the next period start. An accepted word is held unchanged until then.
- R9: With `cfg_slope_en` high, the `dac_code` output is the base reference minus `cfg_slope_step` times the number of clocks so far at or past count (`cfg_period`+1)/2 in the period. The sum of steps saturates at 1023. With `cfg_slope_en` low, `dac_code` equals the base reference.
- R10: `dac_code` never goes below 0. A compensation larger than the base gives 0.
- R11: After reset: count 0, pulse armed, base reference 0, no pending word, `lim_event` and `lim_sticky` low, `ref_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | 12 | Last count of a period (period = value+1 clocks) |
| cfg_max_on | input | 12 | Duty ceiling: gate allowed while count < value |
| cfg_blank | input | 6 | Blanking length in clocks from period start |
| cfg_slope_en | input | 1 | Enable slope compensation |
| cfg_slope_step | input | 10 | Reference decrement per clock in the late half |
| ref_valid | input | 1 | Reference word valid |
| ref_ready | output | 1 | Holding slot free |
| ref_code | input | 10 | Reference word from the control loop |
| cmp_raw | input | 1 | Asynchronous current comparator level (1 = limit reached) |
| lim_clr | input | 1 | Clear the sticky limit flag |
| gate | output | 1 | Power switch drive |
| dac_code | output | 10 | Word for the comparator reference DAC |
| lim_event | output | 1 | One-cycle current-limit termination pulse |
| lim_sticky | output | 1 | Sticky current-limit flag |

## Verification
The gate is driven under several comparator patterns. A quiet comparator shows the duty ceiling alone at work. A held-high comparator with a long blanking window shows that blanking delays the trip to the window's end. Short periodic comparator pulses show that a trip is never undone. Free-running irregular toggling checks the synchronizer latency against periods that end either way. The reference stream is fed a new word on every clock, which shows that words are held through back-pressure and that only one word per period is applied. A small and a large slope step tell the linear decline of the DAC word apart from its clamp at zero.

// File: rtl/pkcm_pkg.sv
package pkcm_pkg;
  localparam int DAC_W = 10;
  typedef logic [DAC_W-1:0] dac_t;

  function automatic dac_t dac_sat_add(dac_t a, dac_t b);
    logic [DAC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DAC_W] ? {DAC_W{1'b1}} : s[DAC_W-1:0];
  endfunction

  function automatic dac_t dac_floor_sub(dac_t a, dac_t b);
    return (a > b) ? dac_t'(a - b) : '0;
  endfunction
endpackage

// File: rtl/pkcm_sync.sv
module pkcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pkcm_timebase.sv
module pkcm_timebase #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             past_half
);
  logic [CNT_W:0] half_w;

  assign wrap      = (cnt == period);
  assign half_w    = ({1'b0, period} + 1'b1) >> 1;
  assign past_half = ({1'b0, cnt} >= half_w);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pkcm_slope.sv
module pkcm_slope
  import pkcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  dac_t step,
  input  dac_t base,
  input  logic wrap,
  input  logic past_half,
  output dac_t dac
);
  dac_t comp_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            comp_q <= '0;
    else if (wrap || !en)  comp_q <= '0;
    else if (past_half)    comp_q <= dac_sat_add(comp_q, step);

  assign dac = dac_floor_sub(base, comp_q);

  // R10
  dac_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac <= base);

  // R9
  dac_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && past_half && !wrap && step != '0 && dac != '0 && $stable(base))
      |=> (dac < $past(dac)) || (base != $past(base)));
endmodule

// File: rtl/pkcm_pwm.sv
module pkcm_pwm
  import pkcm_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int BLANK_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_period,
  input  logic [CNT_W-1:0]   cfg_max_on,
  input  logic [BLANK_W-1:0] cfg_blank,
  input  logic               cfg_slope_en,
  input  logic [DAC_W-1:0]   cfg_slope_step,
  input  logic               ref_valid,
  output logic               ref_ready,
  input  logic [DAC_W-1:0]   ref_code,
  input  logic               cmp_raw,
  input  logic               lim_clr,
  output logic               gate,
  output logic [DAC_W-1:0]   dac_code,
  output logic               lim_event,
  output logic               lim_sticky
);
  localparam int PAD_W = CNT_W - BLANK_W;

  logic [CNT_W-1:0] cnt;
  logic             wrap, past_half, cmp_s;
  logic             alive_q, trip, below_max, blank_done;
  dac_t             base_q, pend_q;
  logic             pend_full, accept;

  pkcm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .period(cfg_period),
    .cnt(cnt), .wrap(wrap), .past_half(past_half)
  );

  pkcm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(cmp_s)
  );

  pkcm_slope u_slope (
    .clk(clk), .rst_n(rst_n), .en(cfg_slope_en), .step(cfg_slope_step),
    .base(base_q), .wrap(wrap), .past_half(past_half), .dac(dac_code)
  );

  assign below_max  = (cnt < cfg_max_on);
  assign blank_done = (cnt >= {{PAD_W{1'b0}}, cfg_blank});
  assign gate       = alive_q && below_max;
  assign trip       = gate && blank_done && cmp_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    alive_q <= 1'b1;
    else if (wrap) alive_q <= 1'b1;
    else if (trip) alive_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lim_event  <= 1'b0;
      lim_sticky <= 1'b0;
    end else begin
      lim_event <= trip;
      if (trip)         lim_sticky <= 1'b1;
      else if (lim_clr) lim_sticky <= 1'b0;
    end

  assign ref_ready = !pend_full;
  assign accept    = ref_valid && !pend_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      base_q    <= '0;
      pend_q    <= '0;
      pend_full <= 1'b0;
    end else begin
      if (wrap && pend_full) base_q <= pend_q;
      if (accept) begin
        pend_q    <= ref_code;
        pend_full <= 1'b1;
      end else if (wrap) begin
        pend_full <= 1'b0;
      end
    end

  // R5
  kill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !wrap) |=> !gate);

  // R7
  sticky_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim_event |-> lim_sticky);

  // R8
  hold_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_full && !wrap) |=> (pend_full && $stable(pend_q)));
endmodule

// File: tb/sim_pkcm_pwm.sv
module sim_pkcm_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_period = 12'd19;
  logic [11:0] cfg_max_on = 12'd12;
  logic [5:0]  cfg_blank = 6'd3;
  logic        cfg_slope_en = 1'b0;
  logic [9:0]  cfg_slope_step = 10'd0;
  logic        ref_valid = 1'b0;
  logic        ref_ready;
  logic [9:0]  ref_code = 10'd0;
  logic        cmp_raw = 1'b0;
  logic        lim_clr = 1'b0;
  logic        gate;
  logic [9:0]  dac_code;
  logic        lim_event, lim_sticky;

  pkcm_pwm u0 (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_max_on(cfg_max_on),
    .cfg_blank(cfg_blank), .cfg_slope_en(cfg_slope_en), .cfg_slope_step(cfg_slope_step),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_code(ref_code),
    .cmp_raw(cmp_raw), .lim_clr(lim_clr), .gate(gate), .dac_code(dac_code),
    .lim_event(lim_event), .lim_sticky(lim_sticky)
  );

  always #2 clk = ~clk;

  int    checks = 0, errors = 0, cyc = 0;
  bit    done = 1'b0;
  string tag = "R11";

  // behavioural reference state
  int m_cnt = 0, m_comp = 0, m_base = 0, m_pend = 0;
  bit m_alive = 1, m_pfull = 0, m_evt = 0, m_sticky = 0;
  bit m_sync[$] = '{0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_comp = 0; m_base = 0; m_pend = 0;
      m_alive = 1; m_pfull = 0; m_evt = 0; m_sticky = 0;
      m_sync = '{0, 0};
    end else begin
      bit w, ph, tr, acc;
      w  = (m_cnt == int'(cfg_period));
      ph = (2 * m_cnt >= int'(cfg_period) + 1) || (m_cnt >= (int'(cfg_period) + 1) / 2);
      tr = m_alive && (m_cnt < int'(cfg_max_on)) && (m_cnt >= int'(cfg_blank)) && m_sync[1];
      m_evt = tr;
      if (tr) m_sticky = 1; else if (lim_clr) m_sticky = 0;
      if (w || !cfg_slope_en) m_comp = 0;
      else if (ph) m_comp = (m_comp + int'(cfg_slope_step) > 1023) ? 1023 : m_comp + int'(cfg_slope_step);
      acc = ref_valid && !m_pfull;
      if (w && m_pfull) m_base = m_pend;
      if (acc) begin m_pend = int'(ref_code); m_pfull = 1; end
      else if (w) m_pfull = 0;
      if (w) m_alive = 1; else if (tr) m_alive = 0;
      m_sync.push_front(cmp_raw);
      void'(m_sync.pop_back());
      m_cnt = w ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d cyc=%0d", tag, nm, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      int ed;
      ed = m_base - m_comp;
      if (ed < 0) ed = 0;
      chk("gate", int'(gate), int'(m_alive && (m_cnt < int'(cfg_max_on))));
      chk("dac_code", int'(dac_code), ed);
      chk("ref_ready", int'(ref_ready), int'(!m_pfull));
      chk("lim_event", int'(lim_event), int'(m_evt));
      chk("lim_sticky", int'(lim_sticky), int'(m_sticky));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R11"; tick(3);
    rst_n = 1'b1;
    tag = "R1"; tick(45);
    tag = "R2"; cfg_max_on = 12'd7; tick(40);
    cfg_max_on = 12'd25; tick(40);
    cfg_max_on = 12'd12;
    tag = "R3";
    for (int i = 0; i < 100; i++) begin cmp_raw = (i % 13) >= 9; tick(1); end
    cmp_raw = 0; tick(20);
    tag = "R4"; cfg_blank = 6'd9; cmp_raw = 1; tick(60);
    cfg_blank = 6'd3; cmp_raw = 0; tick(20);
    tag = "R5";
    for (int i = 0; i < 100; i++) begin cmp_raw = (i % 20) == 4; tick(1); end
    cmp_raw = 0;
    tag = "R6"; tick(40);
    cmp_raw = 1; tick(40);
    tag = "R7"; lim_clr = 1; tick(30);
    cmp_raw = 0; tick(25);
    lim_clr = 0; tick(5); lim_clr = 1; tick(1); lim_clr = 0; tick(20);
    tag = "R8";
    ref_valid = 1;
    for (int i = 0; i < 60; i++) begin ref_code = 10'(100 + i); tick(1); end
    ref_valid = 0; tick(25);
    tag = "R9";
    ref_valid = 1; ref_code = 10'd600; tick(1); ref_valid = 0;
    cfg_slope_en = 1; cfg_slope_step = 10'd7; tick(80);
    tag = "R10";
    ref_valid = 1; ref_code = 10'd300; tick(1); ref_valid = 0;
    cfg_slope_step = 10'd40; tick(80);
    cfg_slope_step = 10'd900; tick(40);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule